// File: doc/BRIEF.md
# Serial Flash Block Erase Controller

This block is the device-side command logic of a serial NOR flash for one operation: erasing a whole 64 KB block. The serial clock, chip select and data input are taken in as signals that are already synchronous to the core clock `clk`. Edges of the serial clock are found by comparing each sample with the one before. Data is sampled on rising serial-clock edges (SPI mode 0) and shifted out on falling ones. While chip select is low, an opcode byte and its address bytes are collected MSB first.

When chip select rises, the block inspects three things: the opcode, the exact number of bits received, and the write-enable latch. It also decodes the block-protection inputs against the target block. If every condition holds, it issues a one-cycle erase request carrying the block index. It then clears the write-enable latch and runs a self-timed busy interval of a fixed number of core cycles, which stands in for the array erase time.

The busy flag and the latch can be read at any time with a status-read command. While busy, the block obeys only status reads.

Top module: `flash_erase_ctrl`

## Requirements
- R1: After reset, the status byte reads 0x00 (no busy, latch clear), `erase_req` is 0 and `miso` is 0.
- R2: Write-enable (opcode 0x06) sets the latch when chip select rises after exactly 8 bits. Status read (opcode 0x05) shifts out the byte {6'b0, latch, busy}, with busy in bit 0 and latch in bit 1. The byte goes out MSB first, each bit appearing after a falling serial-clock edge, and it repeats while chip select stays low.
- R3: Opcode 0xD8 with `addr4_mode`=0 takes a 24-bit address. A chip-select rise after exactly bit 32 produces a single-cycle `erase_req` with `erase_blk` = address bits [16 +: BLK_W].
- R4: Opcode 0xD8 with `addr4_mode`=1 takes a 32-bit address and is accepted only after exactly bit 40. The 24-bit form is rejected in this mode.
- R5: Opcode 0xDC always takes a 32-bit address, accepted after exactly bit 40, for either value of `addr4_mode`.
- R6: A chip-select rise at any other bit count performs no erase and leaves the latch unchanged.
- R7: An erase command with the latch clear is ignored.
- R8: An accepted erase clears the latch and sets busy. Busy stays 1 for ERASE_CYCLES core cycles from the request and then returns to 0.
- R9: A protection level N in 1..15 protects a span of 2^(N-1) blocks, capped at all blocks. The span sits at the top of the block range when `prot_tb`=0 and at the bottom when `prot_tb`=1. Level 0 protects nothing. An erase aimed at a protected block is dropped and the latch is kept.
- R10: While busy, every command except status read is ignored; in particular, write-enable does not set the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock, synchronous to clk |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data in |
| addr4_mode | input | 1 | 1 selects 4-byte addressing for opcode 0xD8 |
| prot_tb | input | 1 | 0 protects from the top block down, 1 from the bottom up |
| prot_lvl | input | 4 | Protection level |
| miso | output | 1 | Serial status data out |
| erase_req | output | 1 | One-cycle erase strobe |
| erase_blk | output | BLK_W | Target block index, valid with erase_req |

## Verification
A miscounted bit counter or a wrong opcode decode shows at the ports on the first chip-select rise: an erase strobe appears when it should not, or is missing when it should appear, or `erase_blk` carries the wrong block. A latch or busy register in the wrong state shows in the next status byte, about eight serial clocks after any status read begins. A busy interval of the wrong length shows in reads placed just before and just after the expected end. A protection decode error shows as a strobe issued for a block at the edge of the protected span.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] OP_ERASE  = 8'hD8;
    localparam logic [7:0] OP_ERASE4 = 8'hDC;
    localparam int         CMD_BITS  = 8;
    localparam int         LEN3_BITS = 32;
    localparam int         LEN4_BITS = 40;
endpackage

// File: rtl/fe_spi_front.sv
module fe_spi_front #(
    parameter int CNT_W = 6,
    parameter int SH_W  = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             cs_n,
    input  logic             mosi,
    output logic             sck_rise,
    output logic             sck_fall,
    output logic             cs_rise,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [SH_W-1:0]  shreg
);
    typedef struct packed {
        logic             sck;
        logic             cs_n;
        logic [CNT_W-1:0] cnt;
        logic [SH_W-1:0]  sh;
    } front_t;

    front_t st_d, st_q;

    assign sck_rise = !cs_n && sck && !st_q.sck;
    assign sck_fall = !cs_n && !sck && st_q.sck;
    assign cs_rise  = cs_n && !st_q.cs_n;
    assign bit_cnt  = st_q.cnt;
    assign shreg    = st_q.sh;

    always_comb begin
        st_d      = st_q;
        st_d.sck  = sck;
        st_d.cs_n = cs_n;
        if (cs_n) begin
            st_d.cnt = '0;
        end else if (sck_rise) begin
            st_d.sh = {st_q.sh[SH_W-2:0], mosi};
            if (st_q.cnt != '1) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sck  <= 1'b0;
            st_q.cs_n <= 1'b1;
            st_q.cnt  <= '0;
            st_q.sh   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    cs_idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (st_q.cnt == '0));
endmodule

// File: rtl/fe_prot_check.sv
module fe_prot_check #(
    parameter int BLK_W = 9
) (
    input  logic [BLK_W-1:0] blk,
    input  logic             prot_tb,
    input  logic [3:0]       prot_lvl,
    output logic             hit
);
    localparam logic [BLK_W:0] NUM_BLK = {1'b1, {BLK_W{1'b0}}};

    logic [BLK_W:0] span;
    logic [BLK_W:0] blk_x;

    assign blk_x = {1'b0, blk};

    always_comb begin
        if (prot_lvl == 4'd0) begin
            span = '0;
        end else if (int'(prot_lvl) > BLK_W) begin
            span = NUM_BLK;
        end else begin
            span = (BLK_W+1)'(1) << (prot_lvl - 4'd1);
        end
    end

    always_comb begin
        if (span == '0) begin
            hit = 1'b0;
        end else if (prot_tb) begin
            hit = blk_x < span;
        end else begin
            hit = blk_x >= (NUM_BLK - span);
        end
    end
endmodule

// File: rtl/fe_erase_timer.sv
module fe_erase_timer #(
    parameter int CYCLES = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign busy = cnt_q != '0;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R10
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R8
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
    import flash_erase_pkg::*;
#(
    parameter int BLK_W        = 9,
    parameter int ERASE_CYCLES = 4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             cs_n,
    input  logic             mosi,
    input  logic             addr4_mode,
    input  logic             prot_tb,
    input  logic [3:0]       prot_lvl,
    output logic             miso,
    output logic             erase_req,
    output logic [BLK_W-1:0] erase_blk
);
    localparam int CNT_W = 6;
    localparam int SH_W  = LEN4_BITS;

    typedef struct packed {
        logic             wel;
        logic             rd_act;
        logic [2:0]       txi;
        logic [7:0]       stat;
        logic             miso;
        logic             req;
        logic [BLK_W-1:0] blk;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic             sck_rise, sck_fall, cs_rise;
    logic [CNT_W-1:0] bit_cnt;
    logic [SH_W-1:0]  shreg;
    logic             busy, prot_hit, start;
    logic             is_er3, is_er4, is_wren;
    logic [31:0]      addr_full;
    logic [BLK_W-1:0] cand_blk;
    logic [7:0]       live_stat, tx_byte;
    logic [7:0]       next_low;

    fe_spi_front #(.CNT_W(CNT_W), .SH_W(SH_W)) u_front (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
        .bit_cnt(bit_cnt), .shreg(shreg)
    );

    fe_prot_check #(.BLK_W(BLK_W)) u_prot (
        .blk(cand_blk), .prot_tb(prot_tb), .prot_lvl(prot_lvl), .hit(prot_hit)
    );

    fe_erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy)
    );

    always_comb begin
        is_er3 = (bit_cnt == CNT_W'(LEN3_BITS)) && (shreg[31:24] == OP_ERASE) && !addr4_mode;
        is_er4 = (bit_cnt == CNT_W'(LEN4_BITS)) &&
                 (((shreg[39:32] == OP_ERASE) && addr4_mode) || (shreg[39:32] == OP_ERASE4));
        is_wren   = (bit_cnt == CNT_W'(CMD_BITS)) && (shreg[7:0] == OP_WREN);
        addr_full = is_er4 ? shreg[31:0] : {8'h00, shreg[23:0]};
        cand_blk  = addr_full[16 +: BLK_W];
        start     = cs_rise && !busy && (is_er3 || is_er4) && st_q.wel && !prot_hit;
        live_stat = {6'b0, st_q.wel, busy};
        next_low  = {shreg[6:0], mosi};
        tx_byte   = (st_q.txi == 3'd0) ? live_stat : st_q.stat;
    end

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (cs_n) begin
            st_d.rd_act = 1'b0;
            st_d.txi    = 3'd0;
            st_d.miso   = 1'b0;
        end
        if (sck_rise && (bit_cnt == CNT_W'(CMD_BITS - 1)) && (next_low == OP_RDSR)) begin
            st_d.rd_act = 1'b1;
        end
        if (sck_fall && st_q.rd_act) begin
            if (st_q.txi == 3'd0) begin
                st_d.stat = live_stat;
            end
            st_d.miso = tx_byte[3'd7 - st_q.txi];
            st_d.txi  = st_q.txi + 3'd1;
        end
        if (cs_rise && !busy && is_wren) begin
            st_d.wel = 1'b1;
        end
        if (start) begin
            st_d.wel = 1'b0;
            st_d.req = 1'b1;
            st_d.blk = cand_blk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso      = st_q.miso;
    assign erase_req = st_q.req;
    assign erase_blk = st_q.blk;

    // R8
    req_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> !st_q.wel);
    // R7
    req_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(st_q.wel));
    // R3
    req_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);
    // R8
    req_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> busy);
endmodule

// File: tb/tb_flash_erase_ctrl.sv
module tb_flash_erase_ctrl;
    localparam int BLK_W = 9;
    localparam int NCYC  = 1000;
    localparam int H     = 4;

    logic clk = 0, rst_n = 0;
    logic sck = 0, cs_n = 1, mosi = 0;
    logic addr4_mode = 0, prot_tb = 0;
    logic [3:0] prot_lvl = 0;
    logic miso, erase_req;
    logic [BLK_W-1:0] erase_blk;

    int checks = 0, errors = 0;
    int cyc = 0, req_cyc = 0;
    int exp_q[$];
    string tag_q[$];
    bit done = 0;

    flash_erase_ctrl #(.BLK_W(BLK_W), .ERASE_CYCLES(NCYC)) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .addr4_mode(addr4_mode), .prot_tb(prot_tb), .prot_lvl(prot_lvl),
        .miso(miso), .erase_req(erase_req), .erase_blk(erase_blk)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // scoreboard monitor: every strobe must match the next expected block
    always @(negedge clk) begin
        if (rst_n && erase_req) begin
            checks++;
            req_cyc = cyc;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected erase (R6/R7/R9): actual blk %0d expected none", erase_blk);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (int'(erase_blk) != e) begin
                    errors++;
                    $display("FAIL %s: erase_blk actual %0d expected %0d", t, erase_blk, e);
                end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [63:0] data, input int nbits, output logic [63:0] rx);
        rx = '0;
        cs_n = 0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = data[nbits-1-i];
            repeat (H) @(negedge clk);
            rx = {rx[62:0], miso};
            sck = 1;
            repeat (H) @(negedge clk);
            sck = 0;
        end
        repeat (H) @(negedge clk);
        cs_n = 1;
        repeat (6) @(negedge clk);
    endtask

    task automatic send(input logic [63:0] data, input int nbits);
        logic [63:0] rx;
        xfer(data, nbits, rx);
    endtask

    task automatic stat_is(input string tag, input logic [7:0] exp);
        logic [63:0] rx;
        xfer({48'h0, 8'h05, 8'h00}, 16, rx);
        check(tag, {24'h0, rx[7:0]}, {24'h0, exp});
    endtask

    task automatic expect_erase(input int blk, input string tag);
        exp_q.push_back(blk);
        tag_q.push_back(tag);
    endtask

    task automatic wait_idle();
        logic [63:0] rx;
        for (int k = 0; k < 60; k++) begin
            xfer({48'h0, 8'h05, 8'h00}, 16, rx);
            if (rx[0] == 1'b0) return;
        end
        check("R8 busy never cleared", 1, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] rx;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R1
        check("R1 erase_req after reset", erase_req, 0);
        check("R1 miso after reset", miso, 0);
        stat_is("R1 status after reset", 8'h00);

        // R2 latch set and repeating status
        send(64'h06, 8);
        stat_is("R2 status after write-enable", 8'h02);
        xfer({40'h0, 8'h05, 16'h0}, 24, rx);
        check("R2 status repeats", {16'h0, rx[15:0]}, 32'h0202);

        // R3 3-byte erase and R8 busy timing, R10 write-enable ignored while busy
        expect_erase(8'h12, "R3 3-byte erase");
        send({32'h0, 8'hD8, 24'h123456}, 32);
        stat_is("R8 busy set latch cleared", 8'h01);
        send(64'h06, 8);
        stat_is("R10 write-enable ignored while busy", 8'h01);
        while (cyc < req_cyc + NCYC - 150) @(negedge clk);
        stat_is("R8 still busy before end", 8'h01);
        while (cyc < req_cyc + NCYC + 10) @(negedge clk);
        stat_is("R8 idle after erase time", 8'h00);

        // R7 no latch, no erase
        send({32'h0, 8'hD8, 24'h070000}, 32);
        stat_is("R7 erase without latch ignored", 8'h00);

        // R6 wrong bit counts
        send(64'h06, 8);
        send({33'h0, 8'hD8, 23'h0}, 31);
        stat_is("R6 short erase keeps latch", 8'h02);
        send({31'h0, 8'hD8, 24'h050000, 1'b0}, 33);
        stat_is("R6 long erase keeps latch", 8'h02);
        expect_erase(5, "R3 erase block 5");
        send({32'h0, 8'hD8, 24'h050000}, 32);
        wait_idle();

        // R4 4-byte mode for D8
        addr4_mode = 1;
        send(64'h06, 8);
        send({32'h0, 8'hD8, 24'h020000}, 32);
        stat_is("R4 3-byte form rejected in 4-byte mode", 8'h02);
        expect_erase(9'h1AB, "R4 4-byte erase");
        send({24'h0, 8'hD8, 32'h01ABCDEF}, 40);
        wait_idle();

        // R5 DC in both modes
        addr4_mode = 0;
        send(64'h06, 8);
        expect_erase(3, "R5 DC mode 0");
        send({24'h0, 8'hDC, 32'h00030000}, 40);
        wait_idle();
        addr4_mode = 1;
        send(64'h06, 8);
        expect_erase(9'h100, "R5 DC mode 1");
        send({24'h0, 8'hDC, 32'h01000000}, 40);
        wait_idle();

        // R9 protection
        prot_tb = 0; prot_lvl = 3;
        send(64'h06, 8);
        send({24'h0, 8'hDC, 32'h01FD0000}, 40);
        stat_is("R9 top block 509 protected", 8'h02);
        expect_erase(507, "R9 block 507 outside top span");
        send({24'h0, 8'hDC, 32'h01FB0000}, 40);
        wait_idle();
        prot_tb = 1;
        send(64'h06, 8);
        send({24'h0, 8'hDC, 32'h00030000}, 40);
        stat_is("R9 bottom block 3 protected", 8'h02);
        expect_erase(4, "R9 block 4 outside bottom span");
        send({24'h0, 8'hDC, 32'h00040000}, 40);
        wait_idle();
        prot_lvl = 15;
        send(64'h06, 8);
        send({24'h0, 8'hDC, 32'h00C80000}, 40);
        stat_is("R9 level 15 protects all", 8'h02);
        prot_lvl = 0; prot_tb = 0;
        expect_erase(511, "R9 level 0 protects none");
        send({24'h0, 8'hDC, 32'h01FF0000}, 40);
        wait_idle();

        repeat (10) @(negedge clk);
        check("R3 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule